// File: doc/BRIEF.md
# Single-Wire Bus Master

This block drives a single-wire, open-drain serial bus on which one or more slave devices share a single data line that is pulled high at rest. The master pulls the line low through an output enable and watches the line through a sampled input. It runs three commands: a bus reset that also detects whether a slave answered, a byte write and a byte read. Every slot is timed in whole microseconds, counted from a tick that a divider makes out of the system clock.

A command is given with a one-cycle `cmd_valid` pulse, an operation code and, for a write, a data byte. It is taken only while the block is idle. `busy` stays high from the clock edge that takes the command to the clock edge that ends it. At that edge `done` pulses for one clock and the result is updated: the presence flag after a reset, the received byte after a read.

The controller has seven states. IDLE waits for a command. RST_LOW pulls the line low, RST_WAIT releases it until the presence sample and RST_TAIL waits out the rest of the reset. SLOT_LOW is the low part of a bit slot. SLOT_SAMP is the released wait before a read sample. SLOT_REC is the released remainder of a slot. The transitions are:
- IDLE to RST_LOW on a reset command, or to SLOT_LOW on a write or read command.
- RST_LOW to RST_WAIT, then to RST_TAIL, then back to IDLE, each when its phase ends.
- SLOT_LOW to SLOT_SAMP for a read, or to SLOT_REC for a write.
- SLOT_SAMP to SLOT_REC.
- SLOT_REC back to SLOT_LOW while bits remain, or to IDLE after the last bit.

Top module: `swb_master`

## Requirements
- R1: A reset command (`cmd_op` = 2'b01) pulls the line for exactly 480 µs and then releases it. `done` rises 960 µs after the command is taken. One µs is CLK_PER_US clocks.
- R2: The line is sampled, through a two-flop synchroniser, 70 µs after the reset releases it. A low sample sets `presence` to 1 and a high sample sets it to 0.
- R3: In a write (`cmd_op` = 2'b10), a bit of value 1 pulls the line for 6 µs and then releases it for 64 µs.
- R4: In a write, a bit of value 0 pulls the line for 60 µs and then releases it for 10 µs.
- R5: A write sends all eight bits of `cmd_data`, bit 0 first, in back-to-back slots. `done` rises at the end of the eighth slot.
- R6: In a read (`cmd_op` = 2'b11), each slot pulls the line for 6 µs and then releases it for 64 µs. The line is sampled 9 µs after the release, and only at that point.
- R7: In a read, the first bit received becomes bit 0 of `rd_byte` and the eighth becomes bit 7.
- R8: `done` is high for one clock only. `busy` is high from the command edge to the `done` edge. The line is never pulled while the block is idle.
- R9: A command is ignored if it arrives while `busy` is high or if its `cmd_op` is 2'b00. An ignored command starts nothing and does not change the timing of the command in progress.
- R10: `presence` changes only when a reset completes and `rd_byte` changes only when a read completes. Other commands leave both unchanged.
- R11: After reset, `bus_pull`, `busy` and `done` are low, `presence` is 0 and `rd_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 01 reset, 10 write byte, 11 read byte, 00 no operation |
| cmd_data | input | BYTE_W | Byte to send for a write |
| bus_in | input | 1 | Sampled level of the bus line |
| bus_pull | output | 1 | Open-drain enable; high pulls the line low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-clock pulse when a command ends |
| presence | output | 1 | 1 if a slave answered the last reset |
| rd_byte | output | BYTE_W | Byte received by the last read |

## Verification
The bench measures the length of every low and released interval, slot by slot, in clock cycles. An off-by-one phase length, or a write that swaps the 1 and 0 slot shapes, shows up as a wrong count. The bench uses asymmetric byte values, so sending the bits in the wrong order or shifting read bits in from the wrong end produces a wrong byte. In one read the slave pulls the line low only for a short window around the 15 µs point of the first slot. A design that samples at release, or at the end of the slot, would read that bit as 1. The bench also sends a command in the middle of a reset and checks that the reset still lasts exactly 960 µs and that nothing runs after it. Finally, it checks that `presence` and `rd_byte` keep their values across commands of the other kinds.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } swb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_RST_TAIL,
        ST_SLOT_LOW,
        ST_SLOT_SAMP,
        ST_SLOT_REC
    } swb_state_e;

endpackage

// File: rtl/swb_usdiv.sv
// Microsecond tick generator; clr realigns the divider to a command start.
module swb_usdiv #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [DW-1:0] div_q;

    assign tick = (div_q == DW'(CLK_PER_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (clr || tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/swb_sync.sv
// Input synchroniser; the bus idles high, so the stages reset to 1.
module swb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg_q <= '1;
                else
                    stg_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg_q <= '1;
                else
                    stg_q <= {stg_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/swb_phase_timer.sv
// Counts microsecond ticks inside one phase and flags the phase's last tick.
module swb_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             phase_end
);
    logic [CNT_W-1:0] cnt_q;

    assign phase_end = tick && (cnt_q == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || phase_end)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/swb_master.sv
module swb_master
    import swb_pkg::*;
#(
    parameter int CLK_PER_US   = 50,
    parameter int SYNC_STAGES  = 2,
    parameter int BYTE_W       = 8,
    parameter int T_RST_LOW    = 480,
    parameter int T_RST_SAMPLE = 70,
    parameter int T_RST_TAIL   = 410,
    parameter int T_W1_LOW     = 6,
    parameter int T_W1_REC     = 64,
    parameter int T_W0_LOW     = 60,
    parameter int T_W0_REC     = 10,
    parameter int T_RD_LOW     = 6,
    parameter int T_RD_SAMPLE  = 9,
    parameter int T_RD_TAIL    = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              bus_in,
    output logic              bus_pull,
    output logic              busy,
    output logic              done,
    output logic              presence,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int CNT_W = $clog2(T_RST_LOW + T_RST_TAIL + 1);
    localparam int BIT_W = $clog2(BYTE_W);

    swb_state_e        state_q, state_d;
    logic              tick, phase_end, accept, bus_s, last_bit;
    logic              is_read_q, pres_smp_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BIT_W-1:0]  bit_idx_q;
    logic [CNT_W-1:0]  phase_len;

    assign accept   = cmd_valid && (state_q == ST_IDLE) && (swb_op_e'(cmd_op) != OP_NONE);
    assign last_bit = (bit_idx_q == BIT_W'(BYTE_W - 1));

    swb_usdiv #(.CLK_PER_US(CLK_PER_US)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .tick  (tick)
    );

    swb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (bus_s)
    );

    swb_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .restart   (accept),
        .len       (phase_len),
        .phase_end (phase_end)
    );

    // Length of the current phase in microseconds
    always_comb begin
        unique case (state_q)
            ST_RST_LOW:   phase_len = CNT_W'(T_RST_LOW);
            ST_RST_WAIT:  phase_len = CNT_W'(T_RST_SAMPLE);
            ST_RST_TAIL:  phase_len = CNT_W'(T_RST_TAIL);
            ST_SLOT_LOW:  phase_len = is_read_q  ? CNT_W'(T_RD_LOW) :
                                      shreg_q[0] ? CNT_W'(T_W1_LOW) : CNT_W'(T_W0_LOW);
            ST_SLOT_SAMP: phase_len = CNT_W'(T_RD_SAMPLE);
            ST_SLOT_REC:  phase_len = is_read_q  ? CNT_W'(T_RD_TAIL) :
                                      shreg_q[0] ? CNT_W'(T_W1_REC) : CNT_W'(T_W0_REC);
            default:      phase_len = CNT_W'(1);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = (swb_op_e'(cmd_op) == OP_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
            end
            ST_RST_LOW:   if (phase_end) state_d = ST_RST_WAIT;
            ST_RST_WAIT:  if (phase_end) state_d = ST_RST_TAIL;
            ST_RST_TAIL:  if (phase_end) state_d = ST_IDLE;
            ST_SLOT_LOW:  if (phase_end) state_d = is_read_q ? ST_SLOT_SAMP : ST_SLOT_REC;
            ST_SLOT_SAMP: if (phase_end) state_d = ST_SLOT_REC;
            ST_SLOT_REC:  if (phase_end) state_d = last_bit ? ST_IDLE : ST_SLOT_LOW;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            presence   <= 1'b0;
            rd_byte    <= '0;
            is_read_q  <= 1'b0;
            pres_smp_q <= 1'b0;
            shreg_q    <= '0;
            bit_idx_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                is_read_q <= (swb_op_e'(cmd_op) == OP_READ);
                shreg_q   <= (swb_op_e'(cmd_op) == OP_WRITE) ? cmd_data : '0;
                bit_idx_q <= '0;
            end
            if (phase_end) begin
                unique case (state_q)
                    ST_RST_WAIT: pres_smp_q <= ~bus_s;
                    ST_RST_TAIL: begin
                        presence <= pres_smp_q;
                        done     <= 1'b1;
                    end
                    ST_SLOT_SAMP: shreg_q <= {bus_s, shreg_q[BYTE_W-1:1]};
                    ST_SLOT_REC: begin
                        if (!is_read_q)
                            shreg_q <= shreg_q >> 1;
                        bit_idx_q <= bit_idx_q + 1'b1;
                        if (last_bit) begin
                            done <= 1'b1;
                            if (is_read_q)
                                rd_byte <= shreg_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign bus_pull = (state_q == ST_RST_LOW) || (state_q == ST_SLOT_LOW);
    assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/swb_master_chk.sv
module swb_master_chk #(
    parameter int CLK_PER_US = 50,
    parameter int T_RST_LOW  = 480,
    parameter int BYTE_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              bus_pull,
    input logic              busy,
    input logic              done,
    input logic              presence,
    input logic [BYTE_W-1:0] rd_byte
);
    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= 0;
        else
            low_run <= bus_pull ? low_run + 1 : 0;
    end

    p_low_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= T_RST_LOW * CLK_PER_US);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_pull_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull |-> busy);

    p_take_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op != 2'b00) |=> busy);

    p_no_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_op != 2'b00)) |=> !busy);

    p_pres_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> done);

    p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_byte) |-> done);
endmodule

bind swb_master swb_master_chk #(
    .CLK_PER_US (CLK_PER_US),
    .T_RST_LOW  (T_RST_LOW),
    .BYTE_W     (BYTE_W)
) u_swb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .bus_pull  (bus_pull),
    .busy      (busy),
    .done      (done),
    .presence  (presence),
    .rd_byte   (rd_byte)
);

// File: tb/swb_master_bench.sv
module swb_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       slave_level = 1'b1;
    logic       bus_in;
    logic       bus_pull, busy, done, presence;
    logic [7:0] rd_byte;
    int         n_total = 0;
    int         n_fail = 0;
    bit         finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign bus_in = !bus_pull && slave_level;

    swb_master #(.CLK_PER_US(P)) u_swb_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .bus_in    (bus_in),
        .bus_pull  (bus_pull),
        .busy      (busy),
        .done      (done),
        .presence  (presence),
        .rd_byte   (rd_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    // Count samples with the line pulled, then released samples until the next pull or done
    task automatic measure(output int lowc, output int highc);
        lowc = 0;
        highc = 0;
        while (bus_pull && lowc < 5000) begin
            lowc++;
            @(negedge clk);
        end
        while (!bus_pull && !done && highc < 5000) begin
            highc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset(input bit present, input logic [7:0] keep_byte);
        int lowc, highc;
        slave_level = !present;
        issue(2'b01, 8'h00);
        chk("R8 busy after take", int'(busy), 1);
        measure(lowc, highc);
        chk("R1 reset low", lowc, 480 * P);
        chk("R1 reset release to done", highc, 480 * P);
        chk("R1 done at end", int'(done), 1);
        chk("R2 presence", int'(presence), int'(present));
        chk("R10 byte kept over reset", int'(rd_byte), int'(keep_byte));
        @(negedge clk);
        chk("R8 done one clock", int'(done), 0);
        chk("R8 idle after done", int'(busy), 0);
        slave_level = 1'b1;
    endtask

    task automatic t_write(input logic [7:0] data, input bit keep_pres, input logic [7:0] keep_byte);
        int lowc, highc;
        slave_level = 1'b1;
        issue(2'b10, data);
        for (int b = 0; b < 8; b++) begin
            measure(lowc, highc);
            if (data[b]) begin
                chk("R3 write-1 low", lowc, 6 * P);
                chk("R3 write-1 release", highc, 64 * P);
            end else begin
                chk("R4 write-0 low", lowc, 60 * P);
                chk("R4 write-0 release", highc, 10 * P);
            end
        end
        chk("R5 done after eighth slot", int'(done), 1);
        chk("R10 presence kept over write", int'(presence), int'(keep_pres));
        chk("R10 byte kept over write", int'(rd_byte), int'(keep_byte));
        @(negedge clk);
        chk("R8 done one clock", int'(done), 0);
    endtask

    task automatic t_read(input logic [7:0] pat, input bit window, input logic [7:0] exp_byte);
        int lowc, highc;
        fork
            begin
                issue(2'b11, 8'h00);
                for (int b = 0; b < 8; b++) begin
                    measure(lowc, highc);
                    chk("R6 read low", lowc, 6 * P);
                    chk("R6 read release", highc, 64 * P);
                end
                chk("R7 done after read", int'(done), 1);
                chk("R7 read byte", int'(rd_byte), int'(exp_byte));
                @(negedge clk);
                chk("R8 done one clock", int'(done), 0);
            end
            begin
                for (int k = 0; k < 8; k++) begin
                    @(posedge bus_pull);
                    if (window && k == 0) begin
                        slave_level = 1'b1;
                        repeat (13 * P) @(negedge clk);
                        slave_level = 1'b0;
                        repeat (4 * P) @(negedge clk);
                        slave_level = 1'b1;
                    end else begin
                        slave_level = pat[k];
                    end
                end
            end
        join
        slave_level = 1'b1;
    endtask

    task automatic t_ignore();
        int t;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'b00;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 no-op not taken", int'(busy), 0);
        chk("R9 no-op no pull", int'(bus_pull), 0);
        slave_level = 1'b1;
        issue(2'b01, 8'h00);
        t = 0;
        repeat (100) begin
            @(negedge clk);
            t++;
        end
        cmd_valid = 1'b1;
        cmd_op    = 2'b10;
        cmd_data  = 8'h00;
        @(negedge clk);
        t++;
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk("R9 reset length unchanged", t, 960 * P);
        chk("R2 presence cleared", int'(presence), 0);
        repeat (50) @(negedge clk);
        chk("R9 nothing started after", int'(busy), 0);
        chk("R9 line free after", int'(bus_pull), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 pull", int'(bus_pull), 0);
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 presence", int'(presence), 0);
        chk("R11 rd_byte", int'(rd_byte), 0);

        t_reset(1'b1, 8'h00);
        t_write(8'hA5, 1'b1, 8'h00);
        t_read(8'h1B, 1'b0, 8'h1B);
        t_reset(1'b0, 8'h1B);
        t_reset(1'b1, 8'h1B);
        t_read(8'hFF, 1'b1, 8'hFE);
        t_ignore();
        t_write(8'h3C, 1'b0, 8'hFE);

        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule